// File: doc/BRIEF.md
# DMA Byte-Count Sequencer for a USB Device Endpoint

This block moves data between one USB device endpoint buffer and an external DMA engine through a request and acknowledge handshake. Software sets it up through a small register port. A configuration word selects the target endpoint, the number of accesses in each request, and the conditions that end the transfer. A 16-bit counter holds the number of bytes that remain. Once enabled, the block raises a request whenever the endpoint is ready. It keeps the request high for a fixed number of acknowledged accesses. Each access moves a 16-bit word, except the final one, which moves a single byte when only one byte is left.

A transfer ends in one of three ways: the counter runs out, a short or empty OUT packet arrives, or software clears the enable bit. In each case the block pulses an end-of-transfer output for one clock and drops its enable. A USB bus reset input clears only the enable bit. Every other programmed field keeps its value, and so does the counter. A read-only status bit records whether the last access moved a byte or a word.

Top module: `dma_xfer_ctl`

## Requirements
- R1: After the synchronous reset, both registers read 0 and `dma_req_o` and `dma_eot_o` are 0.
- R2: The configuration register (`reg_sel_i`=0) uses this layout: bit 0 enable, bits 2:1 burst code, bits 7:4 endpoint index, bit 8 counter-end enable, bit 9 short-packet enable, bit 15 last-width status. Bit 15 is read-only. All other bits read 0, and writes to them have no effect.
- R3: `dma_req_o` rises only when enable is 1, the counter is nonzero and `ep_ready_i` is 1. While it is high, the counter is nonzero.
- R4: The burst code sets how many acknowledged accesses one request lasts: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The last request of a transfer can be cut short when the counter runs out. Between two requests `dma_req_o` is low for at least one cycle.
- R5: A write to the counter register (`reg_sel_i`=1) loads the byte count. Each acknowledged word access subtracts 2 and each byte access subtracts 1. A read returns the bytes still outstanding.
- R6: `dma_word_o` is 1 for a word access. A byte access (`dma_word_o`=0) happens only when exactly one byte remains.
- R7: A pulse on `short_pkt_i` while enabled and with short-packet enable at 1 ends the transfer with EOT. With short-packet enable at 0 the pulse is ignored.
- R8: EOT lasts exactly one cycle and clears the enable bit in the same cycle. It is raised when the counter reaches zero with counter-end enable at 1. With counter-end enable at 0, the counter reaching zero raises no EOT and enable stays 1.
- R9: `bus_rst_i` clears the enable bit, stops requesting and raises no EOT. The burst code, endpoint index, both end enables and the counter keep their values.
- R10: Writing 0 to the enable bit while enabled stops requesting at once and raises EOT. The counter keeps its remaining value.
- R11: Status bit 15 reads 1 if the last acknowledged access moved a word and 0 if it moved a byte.
- R12: `ep_idx_o` presents the programmed endpoint index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | USB bus reset indication; clears enable only |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 configuration, 1 counter |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register, registered one cycle after select |
| ep_ready_i | input | 1 | Endpoint buffer can accept or supply data |
| short_pkt_i | input | 1 | Short or empty OUT packet received (pulse) |
| dma_ack_i | input | 1 | DMA access acknowledge |
| dma_req_o | output | 1 | DMA request |
| dma_word_o | output | 1 | Current access moves a word (1) or a byte (0) |
| dma_eot_o | output | 1 | One-cycle end-of-transfer pulse |
| ep_idx_o | output | 4 | Programmed target endpoint index |

## Verification
The bench targets odd byte counts, which need a closing byte access. A design that always moves words would underflow the counter and leave the width bit at 1. It also runs counts that do not fill the last burst; a burst counter that ignores the remaining bytes would hold the request high past zero. Bus reset is checked separately from software stop, because a design that treats them alike would either raise a false EOT or wipe the programmed fields. Counter-end enable at 0 and short-packet enable at 0 are both run, because a design that ignores those bits would end transfers that should continue.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int EP_W    = 4;
  localparam int BURST_W = 2;
  localparam int BEAT_W  = 4;

  localparam int B_EN    = 0;
  localparam int B_BURST = 1;
  localparam int B_EP    = 4;
  localparam int B_CEOT  = 8;
  localparam int B_SHORT = 9;
  localparam int B_LASTW = 15;

  typedef struct packed {
    logic [EP_W-1:0]    ep;
    logic               short_en;
    logic               cnt_eot_en;
    logic [BURST_W-1:0] burst;
  } dxc_cfg_t;

  function automatic logic [BEAT_W-1:0] burst_beats(input logic [BURST_W-1:0] code);
    return BEAT_W'(1) << code;
  endfunction
endpackage

// File: rtl/dxc_cfg_regs.sv
module dxc_cfg_regs
  import dxc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              eot_set_i,
  input  logic              acc_done_i,
  input  logic              acc_word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic              sw_stop_o,
  output dxc_cfg_t          cfg_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic     en_q;
  logic     lastw_q;
  dxc_cfg_t cfg_q;
  logic     cfg_wr;
  logic [DATA_W-1:0] img;

  assign cfg_wr    = reg_wr_i && !reg_sel_i;
  assign sw_stop_o = cfg_wr && en_q && !reg_wdata_i[B_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      lastw_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q.burst      <= reg_wdata_i[B_BURST +: BURST_W];
        cfg_q.ep         <= reg_wdata_i[B_EP +: EP_W];
        cfg_q.cnt_eot_en <= reg_wdata_i[B_CEOT];
        cfg_q.short_en   <= reg_wdata_i[B_SHORT];
      end
      if (bus_rst_i || eot_set_i) en_q <= 1'b0;
      else if (cfg_wr)            en_q <= reg_wdata_i[B_EN];
      if (acc_done_i) lastw_q <= acc_word_i;
    end
  end

  always_comb begin
    img = '0;
    img[B_EN]                = en_q;
    img[B_BURST +: BURST_W]  = cfg_q.burst;
    img[B_EP +: EP_W]        = cfg_q.ep;
    img[B_CEOT]              = cfg_q.cnt_eot_en;
    img[B_SHORT]             = cfg_q.short_en;
    img[B_LASTW]             = lastw_q;
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata_o <= '0;
    else if (reg_sel_i) reg_rdata_o <= DATA_W'(cnt_i);
    else                reg_rdata_o <= img;
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/dxc_xfer.sv
module dxc_xfer
  import dxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst_i,
  input  logic             en_i,
  input  dxc_cfg_t         cfg_i,
  input  logic             sw_stop_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ep_ready_i,
  input  logic             short_pkt_i,
  input  logic             dma_ack_i,
  output logic             dma_req_o,
  output logic             dma_word_o,
  output logic             dma_eot_o,
  output logic             eot_set_o,
  output logic             acc_done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] beats_q;
  logic              req_q;
  logic              eot_q;
  logic              word;
  logic [CNT_W-1:0]  step;
  logic              zero_hit;
  logic              abort;

  assign word       = cnt_q > CNT_W'(1);
  assign step       = word ? CNT_W'(2) : CNT_W'(1);
  assign acc_done_o = req_q && dma_ack_i;
  assign zero_hit   = acc_done_o && (cnt_q == step);
  assign eot_set_o  = en_i && !bus_rst_i &&
                      ((zero_hit && cfg_i.cnt_eot_en) ||
                       (short_pkt_i && cfg_i.short_en) || sw_stop_i);
  assign abort      = eot_set_o || bus_rst_i || sw_stop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      beats_q <= '0;
      req_q   <= 1'b0;
      eot_q   <= 1'b0;
    end else begin
      eot_q <= eot_set_o;
      if (cnt_wr_i)        cnt_q <= cnt_wdata_i;
      else if (acc_done_o) cnt_q <= cnt_q - step;
      if (abort) begin
        req_q <= 1'b0;
      end else if (req_q) begin
        if (dma_ack_i) begin
          beats_q <= beats_q - BEAT_W'(1);
          if (beats_q == BEAT_W'(1) || cnt_q == step) req_q <= 1'b0;
        end
      end else if (en_i && cnt_q != '0 && ep_ready_i && !cnt_wr_i) begin
        req_q   <= 1'b1;
        beats_q <= burst_beats(cfg_i.burst);
      end
    end
  end

  assign dma_req_o  = req_q;
  assign dma_word_o = req_q && word;
  assign dma_eot_o  = eot_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dxc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ep_ready_i,
  input  logic              short_pkt_i,
  input  logic              dma_ack_i,
  output logic              dma_req_o,
  output logic              dma_word_o,
  output logic              dma_eot_o,
  output logic [EP_W-1:0]   ep_idx_o
);
  logic             en_w;
  logic             sw_stop_w;
  logic             eot_set_w;
  logic             acc_done_w;
  logic [CNT_W-1:0] cnt_w;
  dxc_cfg_t         cfg_w;
  logic [9:0]       fields_w;

  dxc_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .eot_set_i(eot_set_w), .acc_done_i(acc_done_w), .acc_word_i(dma_word_o),
    .cnt_i(cnt_w), .en_o(en_w), .sw_stop_o(sw_stop_w), .cfg_o(cfg_w),
    .reg_rdata_o(reg_rdata_o)
  );

  dxc_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i), .en_i(en_w), .cfg_i(cfg_w),
    .sw_stop_i(sw_stop_w), .cnt_wr_i(reg_wr_i && reg_sel_i),
    .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]), .ep_ready_i(ep_ready_i),
    .short_pkt_i(short_pkt_i), .dma_ack_i(dma_ack_i), .dma_req_o(dma_req_o),
    .dma_word_o(dma_word_o), .dma_eot_o(dma_eot_o), .eot_set_o(eot_set_w),
    .acc_done_o(acc_done_w), .cnt_o(cnt_w)
  );

  assign ep_idx_o = cfg_w.ep;
  assign fields_w = {cfg_w.cnt_eot_en, cfg_w.short_en, cfg_w.ep, cfg_w.burst, 2'b00};
endmodule

// File: rtl/dxc_checks.sv
module dxc_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rst_i,
  input logic             reg_wr_i,
  input logic             reg_sel_i,
  input logic             ep_ready_i,
  input logic             dma_req_o,
  input logic             dma_ack_i,
  input logic             dma_word_o,
  input logic             dma_eot_o,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic [9:0]       fields
);
  a_r8_eot_single: assert property (@(posedge clk) disable iff (rst)
    dma_eot_o |=> !dma_eot_o);
  a_r8_eot_drops_enable: assert property (@(posedge clk) disable iff (rst)
    dma_eot_o |-> !en);
  a_r3_req_start: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req_o) |-> $past(en && cnt != '0 && ep_ready_i));
  a_r3_req_nonzero: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> cnt != '0);
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && dma_ack_i && !(reg_wr_i && reg_sel_i)) |=>
      cnt == $past(cnt) - ($past(dma_word_o) ? CNT_W'(2) : CNT_W'(1)));
  a_r6_byte_last: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && !dma_word_o) |-> cnt == CNT_W'(1));
  a_r9_bus_rst_en: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> (!en && !dma_req_o && !dma_eot_o));
  a_r9_bus_rst_fields: assert property (@(posedge clk) disable iff (rst)
    (bus_rst_i && !reg_wr_i) |=> $stable(fields) && $stable(cnt));
endmodule

bind dma_xfer_ctl dxc_checks #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i), .reg_wr_i(reg_wr_i),
  .reg_sel_i(reg_sel_i), .ep_ready_i(ep_ready_i), .dma_req_o(dma_req_o),
  .dma_ack_i(dma_ack_i), .dma_word_o(dma_word_o), .dma_eot_o(dma_eot_o),
  .en(en_w), .cnt(cnt_w), .fields(fields_w)
);

// File: tb/sim_dma_xfer_ctl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctl;
  logic clk = 0, rst = 1, bus_rst = 0, wr = 0, sel = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic ready = 0, short_pkt = 0, ack = 0;
  logic req, word, eot;
  logic [3:0] ep;
  int n_tests = 0, n_fail = 0, eot_total = 0;

  always #10 clk = ~clk;

  dma_xfer_ctl u0 (
    .clk(clk), .rst(rst), .bus_rst_i(bus_rst), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ep_ready_i(ready),
    .short_pkt_i(short_pkt), .dma_ack_i(ack), .dma_req_o(req),
    .dma_word_o(word), .dma_eot_o(eot), .ep_idx_o(ep)
  );

  always @(negedge clk) if (!rst && eot) eot_total++;

  typedef struct packed {
    logic [1:0]  burst;
    logic [15:0] count;
    logic [7:0]  acc;
    logic [7:0]  bursts;
    logic        last;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 16'd5,  8'd3,  8'd3, 1'b0},
    '{2'd1, 16'd9,  8'd5,  8'd3, 1'b0},
    '{2'd2, 16'd16, 8'd8,  8'd2, 1'b1},
    '{2'd3, 16'd7,  8'd4,  8'd1, 1'b0},
    '{2'd3, 16'd40, 8'd20, 8'd3, 1'b1},
    '{2'd0, 16'd1,  8'd1,  8'd1, 1'b0}
  };

  task automatic chk(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", r, act, act, exp, exp);
    end
  endtask

  task automatic wreg(input logic s, input logic [15:0] d);
    @(negedge clk); wr = 1; sel = s; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic s, output logic [15:0] d);
    @(negedge clk); sel = s;
    @(negedge clk); d = rdata;
  endtask

  task automatic run(input int cyc, output int acc, output int bytes, output int bursts);
    logic prev = 0;
    acc = 0; bytes = 0; bursts = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (req) begin
        ack = 1; acc++; bytes += word ? 2 : 1;
        if (!prev) bursts++;
      end else ack = 0;
      prev = req;
    end
    ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int acc, bytes, bursts, e0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 req", req, 0);
    chk("R1 eot", eot, 0);
    rreg(0, d); chk("R1 cfg", d, 0);
    rreg(1, d); chk("R1 cnt", d, 0);
    // R2 reserved bits read 0, bit 15 read-only
    wreg(0, 16'hFFFE); rreg(0, d); chk("R2 layout", d, 16'h03F6);
    wreg(0, 16'h0000);
    // Table walk: R4 R5 R6 R8 R11 R12
    ready = 1;
    foreach (VECS[i]) begin
      logic [15:0] cfgw;
      cfgw = 16'h0100 | (16'(i + 3) << 4) | (16'(VECS[i].burst) << 1) | 16'h1;
      e0 = eot_total;
      wreg(1, VECS[i].count);
      wreg(0, cfgw);
      chk("R12 ep index", ep, i + 3);
      run(60, acc, bytes, bursts);
      chk("R4 accesses", acc, VECS[i].acc);
      chk("R4 bursts", bursts, VECS[i].bursts);
      chk("R6 bytes moved", bytes, VECS[i].count);
      chk("R8 counter eot", eot_total - e0, 1);
      rreg(0, d);
      chk("R11 cfg after end", d, {VECS[i].last, 15'(cfgw & 16'h03FE)});
      rreg(1, d); chk("R5 counter zero", d, 0);
    end
    // R3 ready low, then R9 bus reset
    ready = 0; e0 = eot_total;
    wreg(1, 16'd4); wreg(0, 16'h0153);
    for (int c = 0; c < 4; c++) begin @(negedge clk); chk("R3 no req when not ready", req, 0); end
    @(negedge clk); bus_rst = 1; @(negedge clk); bus_rst = 0;
    rreg(0, d); chk("R9 fields kept", d, 16'h0152);
    rreg(1, d); chk("R9 counter kept", d, 4);
    chk("R9 no eot", eot_total - e0, 0);
    // R8 counter-end disabled: no EOT, enable stays
    ready = 1;
    wreg(0, 16'h0003);
    run(20, acc, bytes, bursts);
    chk("R8 no eot when disabled", eot_total - e0, 0);
    chk("R5 accesses", acc, 2);
    rreg(0, d); chk("R8 enable kept", d, 16'h8003);
    rreg(1, d); chk("R5 counter", d, 0);
    wreg(0, 16'h0000); repeat (2) @(negedge clk);
    chk("R10 stop eot", eot_total - e0, 1);
    // R7 short packet
    ready = 0; e0 = eot_total;
    wreg(1, 16'd20); wreg(0, 16'h0201);
    @(negedge clk); short_pkt = 1; @(negedge clk); short_pkt = 0;
    @(negedge clk);
    chk("R7 short eot", eot_total - e0, 1);
    rreg(0, d); chk("R7 enable cleared", d, 16'h8200);
    rreg(1, d); chk("R7 counter kept", d, 20);
    e0 = eot_total;
    wreg(0, 16'h0001);
    @(negedge clk); short_pkt = 1; @(negedge clk); short_pkt = 0;
    @(negedge clk);
    chk("R7 short ignored", eot_total - e0, 0);
    rreg(0, d); chk("R7 enable kept", d, 16'h8001);
    @(negedge clk); bus_rst = 1; @(negedge clk); bus_rst = 0;
    // R10 software stop mid-burst
    ready = 1; e0 = eot_total;
    wreg(1, 16'd32); wreg(0, 16'h0107);
    repeat (2) @(negedge clk);
    chk("R4 req held without ack", req, 1);
    @(negedge clk); wr = 1; sel = 0; wdata = 16'h0106;
    @(negedge clk); wr = 0;
    chk("R10 eot now", eot, 1);
    chk("R10 req dropped", req, 0);
    @(negedge clk);
    chk("R8 eot one cycle", eot, 0);
    rreg(1, d); chk("R10 counter kept", d, 32);
    chk("R10 eot count", eot_total - e0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule